// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a freshly powered SDRAM into a usable state once after every reset. It drives the memory's command pins and address bus through a fixed bring-up order: a long idle interval with no-operation commands, one precharge of all banks, a run of auto-refresh commands, and a load of the device mode register. When the last required wait after the mode load has elapsed, it raises a completion flag. The access engine and the periodic refresh logic take over the pins from that point.

All gaps between commands are derived at elaboration time from the clock period and from nanosecond timing parameters. The refresh count, the CAS latency written into the mode word, and the post-mode-load cycle count are also parameters. No data flows through the block, so its pins are plain control and status signals with no handshake. Every output comes straight from a flip-flop, and the address bus carries the mode word one clock before the mode-load command as well as during it.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted, the pins show NOP (cs_n low; ras_n, cas_n and we_n high), the address bus is zero and init_done is low.
- R2: After reset is released, NOP is held for at least STARTUP_CLKS = ceil(T_STARTUP_NS*1000 / CLK_PERIOD_PS) clocks before the first other command, and that command follows no later than two clocks after this minimum.
- R3: The first command is precharge-all (cs_n, ras_n and we_n low; cas_n high), with address bit 10 high.
- R4: The first auto-refresh comes RP_WAITS+1 clocks after the precharge, where RP_WAITS = floor(T_RP_NS*1000 / CLK_PERIOD_PS).
- R5: Exactly REFRESH_COUNT auto-refresh commands (cs_n, ras_n and cas_n low; we_n high) are issued. Each one is followed by RC_WAITS+1 clocks before the next command, where RC_WAITS = floor(T_RC_NS*1000 / CLK_PERIOD_PS).
- R6: The mode-load command has cs_n, ras_n, cas_n and we_n all low. Its address holds the burst length code 010 in bits 2:0, 0 in bit 3 (sequential order), CAS_LAT in bits 6:4, 0 in bit 9 (burst writes) and zero in all other bits. This gives 0x22 for CAS_LAT=2 and 0x12 for CAS_LAT=1.
- R7: The mode word is already on the address bus in the clock before the mode-load command.
- R8: init_done rises exactly TRSC_CLKS clocks after the mode-load command, with only NOP in between.
- R9: Once high, init_done stays high and the command pins stay at NOP until the next reset. A reset applied in mid-sequence restarts the whole sequence from the idle interval.
- R10: Exactly one precharge and exactly one mode-load command are issued per reset, and no command outside the four named ones ever appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus: bit 10 during precharge, mode word around mode load, otherwise zero |
| init_done | output | 1 | High once the sequence has finished; stays high until reset |

## Verification
The bench builds two copies side by side. The first uses an 8 ns period parameter, a 400 ns idle interval, CAS latency 2 and the standard refresh and precharge times. That gives 3 precharge wait clocks, 10 refresh wait clocks and the 0x22 mode word. The second uses a 30 ns period parameter, a 3000 ns idle interval and CAS latency 1. Its precharge wait collapses to zero clocks, so the refresh follows the precharge on the very next edge. It also has 2 refresh wait clocks and the 0x12 mode word. Together they reach both the zero-wait and multi-wait paths of the shared counter, and both CAS latency encodings. A reset pulse inside the idle interval shows the sequence restarting.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_AREF = 2'd2,
    CMD_LMR  = 2'd3
  } sd_cmd_e;

  typedef enum logic [1:0] {
    STEP_PREA = 2'd0,
    STEP_AREF = 2'd1,
    STEP_LMR  = 2'd2,
    STEP_FIN  = 2'd3
  } sd_step_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(sd_cmd_e c);
    case (c)
      CMD_PREA: cmd_pins = 4'b0010;
      CMD_AREF: cmd_pins = 4'b0001;
      CMD_LMR:  cmd_pins = 4'b0000;
      default:  cmd_pins = 4'b0111;
    endcase
  endfunction

  // burst length 4, sequential order, chosen latency, burst writes
  function automatic logic [15:0] mode_word(int cas_lat);
    logic [15:0] w;
    w        = '0;
    w[2:0]   = 3'b010;
    w[3]     = 1'b0;
    w[6:4]   = 3'(cas_lat);
    w[9]     = 1'b0;
    return w;
  endfunction

endpackage

// File: rtl/sdinit_timer.sv
module sdinit_timer #(
  parameter int CNT_W     = 8,
  parameter int RESET_VAL = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= CNT_W'(RESET_VAL);
    else if (load_i)   cnt_q <= load_val_i;
    else if (!zero_o)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // a load is only ever requested once the previous interval has run out
  AST_LOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> zero_o); // R5

endmodule

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int REFRESH_COUNT = 8,
  parameter int RP_WAITS      = 1,
  parameter int RC_WAITS      = 4,
  parameter int RSC_WAITS     = 1,
  parameter int STARTUP_CLKS  = 10
) (
  input  logic    clk,
  input  logic    rst_n,
  output sd_cmd_e cmd_o,
  output logic    mode_lead_o,
  output logic    done_o
);

  localparam int REF_W = $clog2(REFRESH_COUNT + 1);

  sd_step_e         step_q;
  logic [REF_W-1:0] refs_q;
  logic             tmr_zero;
  logic             issue;
  logic             last_ref;
  logic [CNT_W-1:0] gap_val;

  sdinit_timer #(.CNT_W(CNT_W), .RESET_VAL(STARTUP_CLKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (issue),
    .load_val_i(gap_val),
    .zero_o    (tmr_zero)
  );

  assign issue    = tmr_zero && (step_q != STEP_FIN);
  assign last_ref = (step_q == STEP_AREF) && (refs_q == REF_W'(REFRESH_COUNT - 1));

  always_comb begin
    case (step_q)
      STEP_PREA: gap_val = CNT_W'(RP_WAITS);
      STEP_AREF: gap_val = CNT_W'(RC_WAITS);
      STEP_LMR:  gap_val = CNT_W'(RSC_WAITS);
      default:   gap_val = '0;
    endcase
  end

  always_comb begin
    cmd_o = CMD_NOP;
    if (issue) begin
      case (step_q)
        STEP_PREA: cmd_o = CMD_PREA;
        STEP_AREF: cmd_o = CMD_AREF;
        STEP_LMR:  cmd_o = CMD_LMR;
        default:   cmd_o = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= STEP_PREA;
      refs_q <= '0;
    end else if (issue) begin
      case (step_q)
        STEP_PREA: step_q <= STEP_AREF;
        STEP_AREF: begin
          refs_q <= refs_q + 1'b1;
          if (last_ref) step_q <= STEP_LMR;
        end
        STEP_LMR:  step_q <= STEP_FIN;
        default:   step_q <= STEP_FIN;
      endcase
    end
  end

  assign mode_lead_o = (step_q == STEP_LMR) || last_ref;
  assign done_o      = (step_q == STEP_FIN) && tmr_zero;

  AST_REF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    refs_q <= REF_W'(REFRESH_COUNT)); // R5
  AST_DONE_AFTER_ALL_REFS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (refs_q == REF_W'(REFRESH_COUNT))); // R5

endmodule

// File: rtl/sdinit_pins.sv
module sdinit_pins
  import sdinit_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [15:0] MODE_WORD = 16'h0022
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sd_cmd_e           cmd_i,
  input  logic              mode_lead_i,
  input  logic              done_i,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int A10 = 10;

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = '0;
    if (cmd_i == CMD_PREA)  addr_d = ADDR_W'(1) << A10;
    else if (mode_lead_i)   addr_d = MODE_WORD[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_pins(CMD_NOP);
      addr      <= '0;
      init_done <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_pins(cmd_i);
      addr      <= addr_d;
      init_done <= done_i;
    end
  end

  logic pin_prea, pin_lmr, pin_nop;
  assign pin_prea = !cs_n && !ras_n &&  cas_n && !we_n;
  assign pin_lmr  = !cs_n && !ras_n && !cas_n && !we_n;
  assign pin_nop  = !cs_n &&  ras_n &&  cas_n &&  we_n;

  AST_PREA_A10_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pin_prea |-> addr[A10]); // R3
  AST_MODE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    pin_lmr |-> (addr == $past(addr))); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R9
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> pin_nop); // R9

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdinit_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int CLK_PERIOD_PS = 20000,
  parameter int T_STARTUP_NS  = 200000,
  parameter int T_RP_NS       = 24,
  parameter int T_RC_NS       = 80,
  parameter int TRSC_CLKS     = 2,
  parameter int REFRESH_COUNT = 8,
  parameter int CAS_LAT       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int STARTUP_CLKS = (T_STARTUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RP_WAITS     = (T_RP_NS * 1000) / CLK_PERIOD_PS;
  localparam int RC_WAITS     = (T_RC_NS * 1000) / CLK_PERIOD_PS;
  localparam int RSC_WAITS    = TRSC_CLKS - 1;
  localparam int MAX_A        = (STARTUP_CLKS > RC_WAITS) ? STARTUP_CLKS : RC_WAITS;
  localparam int MAX_B        = (RP_WAITS > RSC_WAITS) ? RP_WAITS : RSC_WAITS;
  localparam int MAX_CNT      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W        = $clog2(MAX_CNT + 1);
  localparam logic [15:0] MODE_WORD = mode_word(CAS_LAT);

  sd_cmd_e cmd;
  logic    mode_lead;
  logic    done;

  sdinit_ctrl #(
    .CNT_W        (CNT_W),
    .REFRESH_COUNT(REFRESH_COUNT),
    .RP_WAITS     (RP_WAITS),
    .RC_WAITS     (RC_WAITS),
    .RSC_WAITS    (RSC_WAITS),
    .STARTUP_CLKS (STARTUP_CLKS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_o      (cmd),
    .mode_lead_o(mode_lead),
    .done_o     (done)
  );

  sdinit_pins #(
    .ADDR_W   (ADDR_W),
    .MODE_WORD(MODE_WORD)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd),
    .mode_lead_i(mode_lead),
    .done_i     (done),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .addr       (addr),
    .init_done  (init_done)
  );

endmodule

// File: tb/sdram_powerup_seq_bench.sv
module sdram_powerup_seq_bench;

  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    cs_n, ras_n, cas_n, we_n, done;
  logic [AW-1:0] addr [2];

  sdram_powerup_seq #(
    .ADDR_W(AW), .CLK_PERIOD_PS(8000), .T_STARTUP_NS(400), .T_RP_NS(24),
    .T_RC_NS(80), .TRSC_CLKS(2), .REFRESH_COUNT(8), .CAS_LAT(2)
  ) u_sdram_powerup_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n[0]), .ras_n(ras_n[0]), .cas_n(cas_n[0]),
    .we_n(we_n[0]), .addr(addr[0]), .init_done(done[0])
  );

  sdram_powerup_seq #(
    .ADDR_W(AW), .CLK_PERIOD_PS(30000), .T_STARTUP_NS(3000), .T_RP_NS(24),
    .T_RC_NS(80), .TRSC_CLKS(2), .REFRESH_COUNT(8), .CAS_LAT(1)
  ) u_sdram_powerup_seq_cl1 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n[1]), .ras_n(ras_n[1]), .cas_n(cas_n[1]),
    .we_n(we_n[1]), .addr(addr[1]), .init_done(done[1])
  );

  int checks = 0;
  int errors = 0;

  // 0 NOP, 1 precharge, 2 refresh, 3 mode load, 4 anything else
  function automatic int dec(int k);
    case ({cs_n[k], ras_n[k], cas_n[k], we_n[k]})
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_mode(int cl);
    logic [AW-1:0] w = '0;
    w[2:0] = 3'b010;
    w[6:4] = 3'(cl);
    return w;
  endfunction

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(dec(k) == 0, "R1", "command during reset", dec(k), 0);
      chk(addr[k] == '0, "R1", "address during reset", int'(addr[k]), 0);
      chk(done[k] == 1'b0, "R1", "init_done during reset", int'(done[k]), 0);
    end
  endtask

  // releases reset at a falling edge and follows one instance to completion
  task automatic t_sequence(input int k, input int period_ps, input int startup_ns,
                            input int cl, input int nref, input int trsc);
    int s_clks = (startup_ns * 1000 + period_ps - 1) / period_ps;
    int rp_w   = (24 * 1000) / period_ps;
    int rc_w   = (80 * 1000) / period_ps;
    logic [AW-1:0] mw = exp_mode(cl);
    int cyc = 0, pre_at = -1, mrs_at = -1, done_at = -1, last_at = -1;
    int nrefs = 0, npre = 0, nmrs = 0, nbad = 0, extra = 0;
    logic [AW-1:0] prev_addr = '0;
    rst_n = 1'b1;
    while ((done_at < 0 || extra < 3) && cyc < 3000) begin
      @(posedge clk); @(negedge clk); cyc++;
      case (dec(k))
        1: begin
          npre++; pre_at = cyc; last_at = cyc;
          chk(cyc >= s_clks + 1 && cyc <= s_clks + 3, "R2", "cycle of first command", cyc, s_clks + 1);
          chk(addr[k][10] == 1'b1, "R3", "A10 on precharge", int'(addr[k][10]), 1);
          chk(nrefs == 0 && nmrs == 0, "R3", "commands before precharge", nrefs + nmrs, 0);
        end
        2: begin
          nrefs++;
          if (nrefs == 1) chk(cyc - pre_at == rp_w + 1, "R4", "precharge to refresh gap", cyc - pre_at, rp_w + 1);
          else            chk(cyc - last_at == rc_w + 1, "R5", "refresh to refresh gap", cyc - last_at, rc_w + 1);
          last_at = cyc;
        end
        3: begin
          nmrs++; mrs_at = cyc;
          chk(cyc - last_at == rc_w + 1, "R5", "refresh to mode load gap", cyc - last_at, rc_w + 1);
          chk(nrefs == nref, "R5", "refresh count", nrefs, nref);
          chk(addr[k] == mw, "R6", "mode word", int'(addr[k]), int'(mw));
          chk(prev_addr == mw, "R7", "mode word one clock early", int'(prev_addr), int'(mw));
          last_at = cyc;
        end
        4: nbad++;
        default: ;
      endcase
      if (done[k] && done_at < 0) begin
        done_at = cyc;
        chk(mrs_at > 0 && done_at - mrs_at == trsc, "R8", "mode load to init_done", done_at - mrs_at, trsc);
        chk(last_at == mrs_at, "R8", "command between mode load and done", last_at, mrs_at);
      end else if (done_at > 0) extra++;
      prev_addr = addr[k];
    end
    chk(done_at > 0, "R8", "init_done reached", done_at, 1);
    chk(npre == 1, "R10", "precharge count", npre, 1);
    chk(nmrs == 1, "R10", "mode load count", nmrs, 1);
    chk(nbad == 0, "R10", "unknown commands", nbad, 0);
  endtask

  task automatic t_sticky(input int k);
    int bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (!done[k] || dec(k) != 0) bad++;
    end
    chk(bad == 0, "R9", "init_done held with NOP pins", bad, 0);
  endtask

  task automatic t_midreset(input int k, input int period_ps, input int startup_ns, input int cl);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(dec(k) == 0 && done[k] == 1'b0, "R9", "state after mid-sequence reset", dec(k), 0);
    t_sequence(k, period_ps, startup_ns, cl, 8, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_sequence(0, 8000, 400, 2, 8, 2);
    t_sticky(0);
    t_reset_state();
    t_sequence(1, 30000, 3000, 1, 8, 2);
    t_sticky(1);
    t_reset_state();
    t_midreset(0, 8000, 400, 2);
    t_reset_state();
    t_midreset(1, 30000, 3000, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule